// File: doc/BRIEF.md
# Pipelined unsigned array multiplier

This block multiplies two unsigned operands with a regular array of full-adder cells. There is one row of cells for each bit of the multiplier operand. A cell forms one partial-product bit by ANDing a multiplicand bit with that row's multiplier bit. It then adds that bit to the sum and carry arriving from the row above. Each row keeps its carries in carry-save form, so no carry ripples inside a row. Registers at every row boundary turn the array into a pipeline. A registered carry-propagate adder at the end merges the final sum and carry vectors into the product.

Operands move down the pipeline together with their partial sums. The multiplicand is delayed one stage per row. Each multiplier bit is delayed until the row that consumes it. A valid bit travels with the data. As a result, a new operand pair can be accepted on every clock, and every product leaves the block after a fixed number of edges, flagged by its own valid bit. The default configuration is 5 x 5 bits with a 10-bit product.

Top module: `pipe_array_mult`

## Requirements
- R1: When `out_valid` is high, `out_prod` equals the unsigned product `in_a * in_x` of the operand pair that was accepted with it, written as a 10-bit unsigned number.
- R2: A pair accepted at a rising edge with `in_valid` high produces `out_valid` high after exactly 6 rising edges, counting the capturing edge. In general this is the multiplier width plus one.
- R3: Pairs presented on consecutive cycles are each accepted, with no stall or bubble. Their products come out on consecutive cycles, in arrival order.
- R4: `out_valid` is high for exactly one cycle per accepted pair and at no other time. Operand values present while `in_valid` is low produce no output.
- R5: A synchronous, active-high `rst` clears every valid stage and the product register to zero. Pairs in flight when reset is asserted never appear at the output.
- R6: Boundary operands give exact results: 0 times any value gives 0, any value times 0 gives 0, and 31 * 31 gives 961.
- R7: While `out_valid` is low, `out_prod` keeps the last product delivered. After reset, that value is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks the operand pair on this cycle as a job |
| in_a | input | 5 | Unsigned multiplicand |
| in_x | input | 5 | Unsigned multiplier |
| out_valid | output | 1 | High on the cycle a product is delivered |
| out_prod | output | 10 | Registered unsigned product |

## Verification
Every product is due exactly six rising edges after the edge that captured its operands. Five of those edges are row stages and one is the final carry-propagate register. The driver stamps each queued expectation with the cycle number at which its product must appear. The monitor samples on the falling edge and checks that each product arrives on exactly its stamped cycle. A product that appears early, late or without a queued expectation is reported under R2 or R4. Idle cycles with changing operands, bubbles between jobs, and a reset that falls on jobs in flight show that the valid timing stays exact and that the held product is undisturbed.

// File: rtl/pam_pkg.sv
package pam_pkg;
  // Default geometry of the array.
  localparam int unsigned PAM_A_W = 5;
  localparam int unsigned PAM_X_W = 5;

  // One register per row plus the final carry-propagate register.
  function automatic int unsigned pam_latency(input int unsigned x_w);
    return x_w + 1;
  endfunction
endpackage

// File: rtl/pam_cell.sv
// One array cell: a partial-product bit plus the incoming sum and carry.
module pam_cell (
  input  logic pp,
  input  logic s_in,
  input  logic c_in,
  output logic s_out,
  output logic c_out
);
  assign s_out = pp ^ s_in ^ c_in;
  assign c_out = (pp & s_in) | (pp & c_in) | (s_in & c_in);
endmodule

// File: rtl/pam_row.sv
// One pipeline row: adds a & x_bit, shifted left by ROW, to the
// carry-save pair and registers the result.
module pam_row #(
  parameter int unsigned A_W = 5,
  parameter int unsigned PW  = 10,
  parameter int unsigned ROW = 0
) (
  input  logic          clk,
  input  logic [A_W-1:0] a,
  input  logic          x_bit,
  input  logic [PW-1:0] s_in,
  input  logic [PW-1:0] c_in,
  output logic [PW-1:0] s_q,
  output logic [PW-1:0] c_q
);
  logic [PW-1:0] pp;
  logic [PW-1:0] s_n;
  logic [PW-1:0] c_n;

  assign c_n[0] = 1'b0;

  for (genvar k = 0; k < PW; k++) begin : g_col
    if (k >= ROW && k < ROW + A_W) begin : g_pp
      assign pp[k] = a[k-ROW] & x_bit;
    end else begin : g_nopp
      assign pp[k] = 1'b0;
    end

    if (k < PW - 1) begin : g_cell
      pam_cell u_cell (
        .pp    (pp[k]),
        .s_in  (s_in[k]),
        .c_in  (c_in[k]),
        .s_out (s_n[k]),
        .c_out (c_n[k+1])
      );
    end else begin : g_top
      // The carry out of the top column is always zero, because the product fits PW bits.
      assign s_n[k] = pp[k] ^ s_in[k] ^ c_in[k];
    end
  end

  always_ff @(posedge clk) begin
    s_q <= s_n;
    c_q <= c_n;
  end
endmodule

// File: rtl/pam_resolve.sv
// Final carry-propagate stage with registered, held output.
module pam_resolve #(
  parameter int unsigned PW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          v_in,
  input  logic [PW-1:0] s_in,
  input  logic [PW-1:0] c_in,
  output logic          v_q,
  output logic [PW-1:0] p_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= 1'b0;
      p_q <= '0;
    end else begin
      v_q <= v_in;
      if (v_in) p_q <= s_in + c_in;
    end
  end
endmodule

// File: rtl/pipe_array_mult.sv
module pipe_array_mult
  import pam_pkg::*;
#(
  parameter int unsigned A_W = PAM_A_W,
  parameter int unsigned X_W = PAM_X_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [A_W-1:0]     in_a,
  input  logic [X_W-1:0]     in_x,
  output logic               out_valid,
  output logic [A_W+X_W-1:0] out_prod
);
  localparam int unsigned PW = A_W + X_W;

  // Multiplicand delay line: entry i feeds row i+1.
  logic [A_W-1:0] a_dly [X_W-1];
  logic [A_W-1:0] a_row [X_W];
  // Valid shift: bit r is the valid bit for the output of row r.
  logic [X_W-1:0] v_sh;
  // Skewed multiplier bits: bit j reaches row j after j edges.
  logic [X_W-1:0] x_row;
  logic [PW-1:0]  s_pipe [X_W+1];
  logic [PW-1:0]  c_pipe [X_W+1];

  always_ff @(posedge clk) begin
    a_dly[0] <= in_a;
    for (int i = 1; i < X_W - 1; i++) a_dly[i] <= a_dly[i-1];
  end

  always_comb begin
    a_row[0] = in_a;
    for (int r = 1; r < X_W; r++) a_row[r] = a_dly[r-1];
  end

  always_ff @(posedge clk) begin
    if (rst) v_sh <= '0;
    else     v_sh <= {v_sh[X_W-2:0], in_valid};
  end

  for (genvar j = 0; j < X_W; j++) begin : g_xskew
    if (j == 0) begin : g_now
      assign x_row[0] = in_x[0];
    end else if (j == 1) begin : g_one
      logic x_d;
      always_ff @(posedge clk) x_d <= in_x[1];
      assign x_row[1] = x_d;
    end else begin : g_many
      logic [j-1:0] x_d;
      always_ff @(posedge clk) x_d <= {x_d[j-2:0], in_x[j]};
      assign x_row[j] = x_d[j-1];
    end
  end

  assign s_pipe[0] = '0;
  assign c_pipe[0] = '0;

  for (genvar r = 0; r < X_W; r++) begin : g_row
    pam_row #(.A_W(A_W), .PW(PW), .ROW(r)) u_row (
      .clk   (clk),
      .a     (a_row[r]),
      .x_bit (x_row[r]),
      .s_in  (s_pipe[r]),
      .c_in  (c_pipe[r]),
      .s_q   (s_pipe[r+1]),
      .c_q   (c_pipe[r+1])
    );
  end

  pam_resolve #(.PW(PW)) u_resolve (
    .clk  (clk),
    .rst  (rst),
    .v_in (v_sh[X_W-1]),
    .s_in (s_pipe[X_W]),
    .c_in (c_pipe[X_W]),
    .v_q  (out_valid),
    .p_q  (out_prod)
  );
endmodule

// File: rtl/pam_checker.sv
module pam_checker #(
  parameter int unsigned A_W = 5,
  parameter int unsigned X_W = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic [A_W-1:0]     in_a,
  input logic [X_W-1:0]     in_x,
  input logic               out_valid,
  input logic [A_W+X_W-1:0] out_prod
);
  localparam int unsigned PW  = A_W + X_W;
  localparam int unsigned LAT = X_W + 1;

  logic [LAT-1:0] vh;
  logic [PW-1:0]  ph [LAT];

  always_ff @(posedge clk) begin
    if (rst) vh <= '0;
    else     vh <= {vh[LAT-2:0], in_valid};
  end

  always_ff @(posedge clk) begin
    ph[0] <= PW'(in_a) * PW'(in_x);
    for (int i = 1; i < LAT; i++) ph[i] <= ph[i-1];
  end

  // R2 and R4: a valid output occurs exactly LAT edges after each accepted pair
  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    out_valid == vh[LAT-1]);

  // R1: the delivered product matches the pair accepted LAT edges earlier
  a_r1_product: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_prod == ph[LAT-1]);

  // R5: reset leaves the output cleared
  a_r5_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!out_valid && out_prod == '0));

  // R7: the product register holds its value between deliveries
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_prod));
endmodule

bind pipe_array_mult pam_checker #(.A_W(A_W), .X_W(X_W)) u_chk (.*);

// File: tb/pipe_array_mult_tb.sv
module pipe_array_mult_tb;
  localparam int CLK_PERIOD = 10;
  localparam int A_W = 5;
  localparam int X_W = 5;
  localparam int PW  = A_W + X_W;
  localparam int LAT = 6;   // R2: multiplier width plus one

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [A_W-1:0] in_a = '0;
  logic [X_W-1:0] in_x = '0;
  logic          out_valid;
  logic [PW-1:0] out_prod;

  pipe_array_mult #(.A_W(A_W), .X_W(X_W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_x(in_x),
    .out_valid(out_valid), .out_prod(out_prod)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_checks = 0;
  int n_fail = 0;
  bit mon_on = 1'b0;
  int last_prod = 0;

  int    q_exp[$];
  int    q_due[$];
  string q_tag[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic send(input int a, input int x, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_a = A_W'(a);
    in_x = X_W'(x);
    q_exp.push_back(a * x);
    q_due.push_back(cyc + LAT);
    q_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_a = A_W'($urandom);
      in_x = X_W'($urandom);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    q_exp.delete();
    q_due.delete();
    q_tag.delete();
    // R5: output cleared while reset is applied
    check(out_valid == 1'b0, "R5", int'(out_valid), 0);
    check(out_prod == '0, "R5", int'(out_prod), 0);
    last_prod = 0;
    rst = 1'b0;
  endtask

  // Monitor: the scoreboard side
  always @(negedge clk) begin
    if (!rst && mon_on) begin
      if (out_valid) begin
        if (q_exp.size() == 0) begin
          check(1'b0, "R4 spurious out_valid", 1, 0);
        end else begin
          int e, d;
          string t;
          e = q_exp.pop_front();
          d = q_due.pop_front();
          t = q_tag.pop_front();
          check(int'(out_prod) == e, t, int'(out_prod), e);
          check(cyc == d, "R2 delivery cycle", cyc, d);
        end
        last_prod = int'(out_prod);
      end else begin
        if (q_due.size() > 0 && q_due[0] <= cyc) begin
          check(1'b0, "R2 product missing", cyc, q_due[0]);
          void'(q_exp.pop_front());
          void'(q_due.pop_front());
          void'(q_tag.pop_front());
        end
        check(int'(out_prod) == last_prod, "R7 hold", int'(out_prod), last_prod);
      end
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R2: watchdog expired, actual %0d expected 0 pending", q_exp.size());
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R5: reset state
    check(out_valid == 1'b0, "R5", int'(out_valid), 0);
    check(out_prod == '0, "R5", int'(out_prod), 0);
    rst = 1'b0;
    mon_on = 1'b1;

    // R6: boundary operands, with gaps between them
    send(0, 17, "R6 zero a");
    idle(3);
    send(22, 0, "R6 zero x");
    idle(1);
    send(31, 31, "R6 max 961");
    send(31, 1, "R6");
    idle(LAT + 2);

    // R1 and R3: every pair, back to back
    for (int a = 0; a < 32; a++)
      for (int x = 0; x < 32; x++)
        send(a, x, "R1 R3 exhaustive");
    idle(LAT + 2);

    // R4: bubbles with changing operands between jobs
    for (int i = 0; i < 64; i++) begin
      send(i % 32, (i * 7 + 3) % 32, "R4 bubbles");
      if (i % 3 == 0) idle(1 + (i % 2));
    end
    idle(LAT + 2);

    // R5: a reset falls on jobs in flight; none of them may appear
    send(9, 9, "R5 flushed");
    send(12, 30, "R5 flushed");
    send(31, 31, "R5 flushed");
    do_reset();
    idle(LAT + 3);
    send(5, 6, "R5 recovery");
    idle(LAT + 2);

    // R3: nothing left undelivered
    check(q_exp.size() == 0, "R3 queue drained", q_exp.size(), 0);
    finish_run();
  end
endmodule